// File: doc/BRIEF.md
# Sequenced Lane Power Switch

This block switches the power of four serial transmit lanes one lane at a time. It does not switch them all in the same cycle. A host presents a request on its inputs: the target power state, the direction of the walk across the lanes, a gap length and a lane count. It then pulses a trigger. The block latches the request and visits lane positions one per step. Between steps it waits a gap of `gap_i` delay units, and each unit lasts `UNIT_CYC` clock cycles.

The block reports progress with a busy flag and a done flag. Done falls when a request is accepted and rises again only on the clock edge where the last lane position switches. Host software can poll done with confidence, because the whole sequence ends within a fixed number of cycles that depends only on the gap field. For power-up, the usual host setting walks from lane 3 down to lane 0. For power-down, it walks from lane 0 up to lane 3. Typical gaps are 1 unit for a packet link and 15 units for a low-swing parallel link.

Top module: `lane_pwr_seq`

## Requirements
- R1: After reset, `lane_pd_o` is 4'b1111 (every lane powered down), `busy_o` is 0 and `done_o` is 1.
- R2: A `trig_i` pulse that is sampled while `busy_o` is 0 and `lane_cnt_i` is 1, 2 or 4 is accepted. On the following edge `busy_o` becomes 1 and `done_o` becomes 0.
- R3: The enabled set follows the accepted `lane_cnt_i`: 1 enables lane 0, 2 enables lanes 0 and 1, and 4 enables lanes 0 to 3. Lanes outside the set read 1 in `lane_pd_o` from the acceptance edge onward, whatever the request.
- R4: With `dir_down_i`=1 the lanes are visited in the order 3, 2, 1, 0. With `dir_down_i`=0 the order is 0, 1, 2, 3. A visited enabled lane takes `lane_pd_o` bit = ~`pwr_up_i`, and at most one bit of `lane_pd_o` changes per edge while busy.
- R5: Take the acceptance edge as edge 0 and let P = `gap_i`*`UNIT_CYC`+1. Visit k (k=0..3) happens on edge 1+k*P, so a gap of 0 visits lanes on consecutive edges.
- R6: `busy_o` falls and `done_o` rises on the edge of the last visit, edge 1+3*P. This is never more than 1+3*((2^GAP_W-1)*UNIT_CYC+1) cycles after acceptance.
- R7: A trigger that arrives while `busy_o` is 1 is ignored: the running sequence keeps its fields, order and timing.
- R8: A trigger with `lane_cnt_i` set to 0, 3, 5, 6 or 7 is rejected: `busy_o` stays 0, `done_o` stays 1 and `lane_pd_o` is unchanged.
- R9: While idle and without an accepted trigger, `lane_pd_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | One-cycle request strobe |
| pwr_up_i | input | 1 | Target state: 1 powers lanes up, 0 powers them down |
| dir_down_i | input | 1 | Walk order: 1 is lane 3 to 0, 0 is lane 0 to 3 |
| gap_i | input | GAP_W | Gap between visits, in delay units |
| lane_cnt_i | input | 3 | Enabled lane count (1, 2 or 4) |
| lane_pd_o | output | 4 | Per-lane power-down, 1 = lane off |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last request finished (or none pending) |

## Verification
The assertions assume that the request fields only matter in the cycle where `trig_i` is high, and that `trig_i` is a synchronous strobe. They make no assumption about how often it is pulsed. The stimulus drives every input at the falling clock edge, so a trigger is sampled with its fields already stable. The sweep covers both power targets, both walk orders, gaps 0, 1, 3 and 15, and all three legal lane counts. A retrigger is injected in the middle of sequences, and every illegal count is presented while idle, so the rejection and busy-ignore properties are exercised and not left vacuous.

// File: rtl/lane_pwr_seq.sv
module lane_pwr_seq #(
  parameter int GAP_W    = 4,
  parameter int UNIT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             pwr_up_i,
  input  logic             dir_down_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic [2:0]       lane_cnt_i,
  output logic [3:0]       lane_pd_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int LANES    = 4;
  localparam int MAX_WAIT = (2**GAP_W - 1) * UNIT_CYC;
  localparam int WAIT_W   = $clog2(MAX_WAIT + 1);

  logic [LANES-1:0] mask_q, pd_q, new_mask;
  logic             up_q, dir_q, busy_q, done_q;
  logic [GAP_W-1:0] gap_q;
  logic [1:0]       step_q, idx;
  logic [WAIT_W-1:0] wait_q, reload;
  logic             cnt_ok, accept;

  always_comb begin
    cnt_ok   = 1'b1;
    new_mask = '0;
    case (lane_cnt_i)
      3'd1:    new_mask = 4'b0001;
      3'd2:    new_mask = 4'b0011;
      3'd4:    new_mask = 4'b1111;
      default: cnt_ok   = 1'b0;
    endcase
  end

  assign accept = trig_i & ~busy_q & cnt_ok;
  assign idx    = dir_q ? 2'(LANES - 1) - step_q : step_q;
  assign reload = WAIT_W'(int'(gap_q) * UNIT_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q   <= '1;
      mask_q <= '1;
      up_q   <= 1'b0;
      dir_q  <= 1'b0;
      gap_q  <= '0;
      step_q <= '0;
      wait_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end else if (accept) begin
      mask_q <= new_mask;
      up_q   <= pwr_up_i;
      dir_q  <= dir_down_i;
      gap_q  <= gap_i;
      step_q <= '0;
      wait_q <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
      pd_q   <= pd_q | ~new_mask;
    end else if (busy_q) begin
      if (wait_q == '0) begin
        pd_q[idx] <= mask_q[idx] ? ~up_q : 1'b1;
        if (step_q == 2'(LANES - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          step_q <= step_q + 2'd1;
          wait_q <= reload;
        end
      end else begin
        wait_q <= wait_q - 1'b1;
      end
    end
  end

  assign lane_pd_o = pd_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
endmodule

// File: rtl/lane_pwr_seq_chk.sv
module lane_pwr_seq_chk #(
  parameter int GAP_W    = 4,
  parameter int UNIT_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       trig_i,
  input logic [2:0] lane_cnt_i,
  input logic [3:0] lane_pd_o,
  input logic       busy_o,
  input logic       done_o
);
  localparam int LIMIT = 1 + 3 * ((2**GAP_W - 1) * UNIT_CYC + 1);

  logic [31:0] busy_cnt;
  logic        cnt_legal;
  assign cnt_legal = (lane_cnt_i == 3'd1) || (lane_cnt_i == 3'd2) || (lane_cnt_i == 3'd4);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= '0;

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o)); // R2
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !busy_o && cnt_legal) |=> (busy_o && !done_o)); // R2
  AST_ONE_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !trig_i) |=> ($countones(lane_pd_o ^ $past(lane_pd_o)) <= 1)); // R4
  AST_DONE_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R6
  AST_BOUNDED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (busy_cnt < LIMIT)); // R6
  AST_BAD_CNT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !busy_o && !cnt_legal) |=> (!busy_o && done_o && $stable(lane_pd_o))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !trig_i) |=> $stable(lane_pd_o)); // R9
endmodule

bind lane_pwr_seq lane_pwr_seq_chk #(.GAP_W(GAP_W), .UNIT_CYC(UNIT_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .lane_cnt_i(lane_cnt_i),
  .lane_pd_o(lane_pd_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/lane_pwr_seq_tb_top.sv
module lane_pwr_seq_tb_top;
  localparam int GW = 4;
  localparam int UC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig_i = 1'b0, pwr_up_i = 1'b0, dir_down_i = 1'b0;
  logic [GW-1:0] gap_i = '0;
  logic [2:0]    lane_cnt_i = 3'd1;
  logic [3:0]    lane_pd_o;
  logic          busy_o, done_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] m_pd;

  always #5 clk = ~clk;

  lane_pwr_seq #(.GAP_W(GW), .UNIT_CYC(UC)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .pwr_up_i(pwr_up_i),
    .dir_down_i(dir_down_i), .gap_i(gap_i), .lane_cnt_i(lane_cnt_i),
    .lane_pd_o(lane_pd_o), .busy_o(busy_o), .done_o(done_o));

  task automatic cmp(string tag, logic [3:0] epd, logic ebusy, logic edone);
    checks++;
    if (lane_pd_o !== epd || busy_o !== ebusy || done_o !== edone) begin
      errors++;
      $display("FAIL %s: pd/busy/done got %b/%b/%b expected %b/%b/%b at %0t",
               tag, lane_pd_o, busy_o, done_o, epd, ebusy, edone, $time);
    end
  endtask

  task automatic run(logic up, logic dir, int gap, int cnt, bit inject);
    logic [3:0] mask;
    int p, last;
    logic eb, ed;
    mask = (cnt == 4) ? 4'b1111 : (cnt == 2) ? 4'b0011 : 4'b0001;
    p = gap * UC + 1;
    last = 1 + 3 * p;
    eb = 1'b0; ed = 1'b1;
    pwr_up_i = up; dir_down_i = dir; gap_i = GW'(gap); lane_cnt_i = 3'(cnt);
    trig_i = 1'b1;
    for (int t = 0; t <= last; t++) begin
      @(posedge clk); @(negedge clk);
      if (t == 0) begin
        m_pd = m_pd | ~mask; eb = 1'b1; ed = 1'b0;
      end else if ((t - 1) % p == 0) begin
        int k, ln;
        k = (t - 1) / p;
        ln = dir ? 3 - k : k;
        m_pd[ln] = mask[ln] ? ~up : 1'b1;
        if (k == 3) begin eb = 1'b0; ed = 1'b1; end
      end
      if (t == 0)         cmp("R2/R3 accept", m_pd, eb, ed);
      else if (t == last) cmp("R6 finish", m_pd, eb, ed);
      else if (inject)    cmp("R7 retrigger ignored", m_pd, eb, ed);
      else                cmp("R4/R5 lane walk", m_pd, eb, ed);
      trig_i = 1'b0;
      if (inject && t == 1) begin
        trig_i = 1'b1; pwr_up_i = ~up; dir_down_i = ~dir;
        gap_i = GW'(0); lane_cnt_i = 3'd4;
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int gaps [4] = '{0, 1, 3, 15};
    int cnts [3] = '{1, 2, 4};
    int bad  [5] = '{0, 3, 5, 6, 7};
    repeat (3) @(negedge clk);
    cmp("R1 reset", 4'b1111, 1'b0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 after release", 4'b1111, 1'b0, 1'b1);
    m_pd = 4'b1111;
    for (int u = 1; u >= 0; u--)
      for (int d = 0; d < 2; d++)
        for (int g = 0; g < 4; g++)
          for (int c = 0; c < 3; c++)
            run(u[0], d[0], gaps[g], cnts[c], 1'b0);
    run(1'b1, 1'b1, 3, 4, 1'b1);
    run(1'b1, 1'b0, 1, 2, 1'b1);
    for (int b = 0; b < 5; b++) begin
      lane_cnt_i = 3'(bad[b]); pwr_up_i = ~pwr_up_i; trig_i = 1'b1;
      @(posedge clk); @(negedge clk);
      trig_i = 1'b0;
      cmp("R8 bad count rejected", m_pd, 1'b0, 1'b1);
      @(posedge clk); @(negedge clk);
      cmp("R8 bad count rejected", m_pd, 1'b0, 1'b1);
    end
    repeat (6) @(negedge clk);
    cmp("R9 idle hold", m_pd, 1'b0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule